// File: doc/BRIEF.md
# Multi-port SDRAM request scheduler

This block sits in front of one multi-bank SDRAM controller. It picks the next memory command from eight candidates. Each of four independent bus ports gives one direct request, and the write buffer behind each port gives one flush request. Ports 0 and 1 carry latency-sensitive traffic, such as processors. Ports 2 and 3 carry throughput traffic, such as graphics and DMA.

When the block is idle and work is pending, it selects one candidate and holds the selection until the controller accepts it. The choice uses three rules:
- A candidate whose bank differs from the bank of the last issued command is preferred.
- Within the same conflict status, the latency class is preferred.
- Within a tier, the order is round robin.

A candidate that has waited through eight other issues is forced through ahead of everything else. The block drives a grant to the winning requester and presents that requester's address, direction and length on the command interface. A requester holds its request and fields stable until it is granted.

Top module: `mport_sched`

## Requirements
- R1: While rst_ni is low and after its release with no requests, cmd_valid_o, port_gnt_o and wb_gnt_o are all zero.
- R2: At most one grant is asserted, and only to a candidate whose request is high. A flush from a write buffer is always issued as a write (cmd_we_o = 1).
- R3: While cmd_valid_o is high and cmd_ready_i is low, the grant, cmd_src_o and the command fields stay unchanged.
- R4: A selection is made on the first rising edge at which the block is idle and a request is pending. After an accepted handshake (cmd_valid_o and cmd_ready_i high at an edge), cmd_valid_o is low for at least one cycle.
- R5: The bank is address bits [12:11]. A pending candidate whose bank differs from the bank of the last accepted command wins over any candidate with the same bank, whatever its class. Before the first accepted command, no candidate is in conflict.
- R6: Among candidates with the same conflict status, candidates of ports 0 and 1 and their write buffers win over those of ports 2 and 3.
- R7: Candidates are indexed 0 to 3 for the direct requests of ports 0 to 3 and 4 to 7 for the flushes of ports 0 to 3. Within one tier, the winner is the first pending index at or after the index following the last accepted candidate, wrapping at 8.
- R8: A candidate that stays pending while 8 commands from other candidates are accepted wins the next selection over all non-starved candidates.
- R9: cmd_src_o gives the index of the selected candidate (R7 encoding). cmd_addr_o, cmd_we_o and cmd_len_o equal that candidate's inputs, and the matching grant bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_req_i | input | 4 | Direct request per bus port |
| port_addr_i | input | 128 | Address per port, 32 bits each, port p at bits [32p+31:32p] |
| port_we_i | input | 4 | Write flag per port |
| port_len_i | input | 16 | Burst length per port, 4 bits each |
| wb_req_i | input | 4 | Flush request per write buffer |
| wb_addr_i | input | 128 | Flush address per write buffer |
| wb_len_i | input | 16 | Flush length per write buffer |
| port_gnt_o | output | 4 | Grant per direct request |
| wb_gnt_o | output | 4 | Grant per write-buffer flush |
| cmd_valid_o | output | 1 | Command valid to the controller |
| cmd_ready_i | input | 1 | Controller accepts the command |
| cmd_addr_o | output | 32 | Selected address |
| cmd_we_o | output | 1 | Selected direction, 1 = write |
| cmd_len_o | output | 4 | Selected length |
| cmd_src_o | output | 3 | Selected candidate index |

## Verification
A lone throughput read with the controller stalling checks selection timing, hold behaviour and field routing. A latency request on the busy bank against a throughput request on a free bank shows that conflict avoidance outranks class. Two conflict-free requests of different classes then show class priority, and a lone flush shows the forced write direction. A pending high index joined by a lower one after the pointer has moved separates round robin from fixed priority. A throughput request held against an endless alternation of latency requests on free banks must break through on exactly the ninth issue.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    TIER_FREE_LAT,
    TIER_FREE_THR,
    TIER_BUSY_LAT,
    TIER_BUSY_THR
  } tier_e;
endpackage

// File: rtl/sched_age.sv
module sched_age #(
  parameter int NC    = 8,
  parameter int LIMIT = 8,
  localparam int IW   = $clog2(NC),
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] req_i,
  input  logic          fire_i,
  input  logic [IW-1:0] sel_i,
  output logic [NC-1:0] starved_o
);
  for (genvar c = 0; c < NC; c++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (!req_i[c]) cnt_q <= '0;
      else if (fire_i) begin
        if (sel_i == IW'(c)) cnt_q <= '0;
        else if (cnt_q < CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
      end
    end
    assign starved_o[c] = (cnt_q >= CW'(LIMIT));
  end
endmodule

// File: rtl/sched_tier.sv
module sched_tier
  import sched_pkg::*;
#(
  parameter int NC = 8
) (
  input  logic [NC-1:0] req_i,
  input  logic [NC-1:0] conf_i,
  input  logic [NC-1:0] lat_i,
  input  logic [NC-1:0] starved_i,
  output logic [NC-1:0] mask_o
);
  tier_e tier;
  logic [NC-1:0] starve_m, free_lat, free_thr, busy_lat, busy_thr;

  always_comb begin
    starve_m = req_i & starved_i;
    free_lat = req_i & ~conf_i & lat_i;
    free_thr = req_i & ~conf_i & ~lat_i;
    busy_lat = req_i & conf_i & lat_i;
    busy_thr = req_i & conf_i & ~lat_i;
    if (|free_lat)      tier = TIER_FREE_LAT;
    else if (|free_thr) tier = TIER_FREE_THR;
    else if (|busy_lat) tier = TIER_BUSY_LAT;
    else                tier = TIER_BUSY_THR;
    if (|starve_m) mask_o = starve_m;
    else begin
      case (tier)
        TIER_FREE_LAT: mask_o = free_lat;
        TIER_FREE_THR: mask_o = free_thr;
        TIER_BUSY_LAT: mask_o = busy_lat;
        default:       mask_o = busy_thr;
      endcase
    end
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_i) + k) % N;
      if (!found_o && mask_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/mport_sched.sv
module mport_sched #(
  parameter int          NP       = 4,
  parameter int          AW       = 32,
  parameter int          LW       = 4,
  parameter int          BANK_LSB = 11,
  parameter int          BANK_W   = 2,
  parameter int          STARVE   = 8,
  parameter logic [NP-1:0] LAT_MASK = 4'b0011,
  localparam int         NC       = 2 * NP,
  localparam int         IW       = $clog2(NC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    port_req_i,
  input  logic [NP*AW-1:0] port_addr_i,
  input  logic [NP-1:0]    port_we_i,
  input  logic [NP*LW-1:0] port_len_i,
  input  logic [NP-1:0]    wb_req_i,
  input  logic [NP*AW-1:0] wb_addr_i,
  input  logic [NP*LW-1:0] wb_len_i,
  output logic [NP-1:0]    port_gnt_o,
  output logic [NP-1:0]    wb_gnt_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             cmd_we_o,
  output logic [LW-1:0]    cmd_len_o,
  output logic [IW-1:0]    cmd_src_o
);
  logic [AW-1:0]     cand_addr [NC];
  logic [LW-1:0]     cand_len  [NC];
  logic [NC-1:0]     cand_we, cand_lat, cand_conf, cand_req, starved, pick_mask;
  logic              busy_q, last_vld_q, found, fire;
  logic [IW-1:0]     sel_q, ptr_q, pick;
  logic [BANK_W-1:0] last_bank_q;
  logic [NC-1:0]     gvec;

  assign cand_req = {wb_req_i, port_req_i};

  for (genvar c = 0; c < NC; c++) begin : g_cand
    if (c < NP) begin : g_port
      assign cand_addr[c] = port_addr_i[c*AW +: AW];
      assign cand_len[c]  = port_len_i[c*LW +: LW];
      assign cand_we[c]   = port_we_i[c];
    end else begin : g_wb
      assign cand_addr[c] = wb_addr_i[(c-NP)*AW +: AW];
      assign cand_len[c]  = wb_len_i[(c-NP)*LW +: LW];
      assign cand_we[c]   = 1'b1;
    end
    assign cand_lat[c]  = LAT_MASK[c % NP];
    assign cand_conf[c] = last_vld_q && (cand_addr[c][BANK_LSB +: BANK_W] == last_bank_q);
  end

  sched_age #(.NC(NC), .LIMIT(STARVE)) u_age (
    .clk_i, .rst_ni, .req_i(cand_req), .fire_i(fire), .sel_i(sel_q), .starved_o(starved)
  );

  sched_tier #(.NC(NC)) u_tier (
    .req_i(cand_req), .conf_i(cand_conf), .lat_i(cand_lat),
    .starved_i(starved), .mask_o(pick_mask)
  );

  sched_rr_pick #(.N(NC)) u_pick (
    .mask_i(pick_mask), .ptr_i(ptr_q), .found_o(found), .idx_o(pick)
  );

  assign fire = busy_q && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      sel_q       <= '0;
      ptr_q       <= '0;
      last_vld_q  <= 1'b0;
      last_bank_q <= '0;
    end else if (fire) begin
      busy_q      <= 1'b0;
      last_vld_q  <= 1'b1;
      last_bank_q <= cand_addr[sel_q][BANK_LSB +: BANK_W];
      ptr_q       <= (sel_q == IW'(NC-1)) ? '0 : sel_q + 1'b1;
    end else if (!busy_q && found) begin
      busy_q <= 1'b1;
      sel_q  <= pick;
    end
  end

  assign gvec        = busy_q ? (NC'(1) << sel_q) : '0;
  assign port_gnt_o  = gvec[NP-1:0];
  assign wb_gnt_o    = gvec[NC-1:NP];
  assign cmd_valid_o = busy_q;
  assign cmd_src_o   = sel_q;
  assign cmd_addr_o  = cand_addr[sel_q];
  assign cmd_we_o    = cand_we[sel_q];
  assign cmd_len_o   = cand_len[sel_q];
endmodule

// File: rtl/mport_sched_chk.sv
module mport_sched_chk #(
  parameter int NP = 4,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NP-1:0] port_req_i,
  input logic [NP-1:0] wb_req_i,
  input logic [NP-1:0] port_gnt_o,
  input logic [NP-1:0] wb_gnt_o,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [IW-1:0] cmd_src_o
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_gnt_o, port_gnt_o}));
  // R2
  grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({wb_gnt_o, port_gnt_o} & ~{wb_req_i, port_req_i}) == '0);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_src_o) && $stable({wb_gnt_o, port_gnt_o}));
  // R4
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);
  // R4
  pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o && (|{wb_req_i, port_req_i}) |=> cmd_valid_o);
  // R9
  valid_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == (|{wb_gnt_o, port_gnt_o}));
endmodule

bind mport_sched mport_sched_chk #(.NP(NP), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_req_i(port_req_i), .wb_req_i(wb_req_i),
  .port_gnt_o(port_gnt_o), .wb_gnt_o(wb_gnt_o), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_src_o(cmd_src_o)
);

// File: tb/sim_mport_sched.sv
`timescale 1ns/1ps
module sim_mport_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   port_req = '0, port_we = '0, wb_req = '0;
  logic [127:0] port_addr = '0, wb_addr = '0;
  logic [15:0]  port_len = '0, wb_len = '0;
  logic [3:0]   port_gnt, wb_gnt;
  logic         cmd_valid, cmd_ready = 1'b0, cmd_we;
  logic [31:0]  cmd_addr;
  logic [3:0]   cmd_len;
  logic [2:0]   cmd_src;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_addr [8];
  logic        exp_we   [8];
  logic [3:0]  exp_len  [8];

  always #10 clk = ~clk;

  mport_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_req_i(port_req), .port_addr_i(port_addr),
    .port_we_i(port_we), .port_len_i(port_len), .wb_req_i(wb_req), .wb_addr_i(wb_addr),
    .wb_len_i(wb_len), .port_gnt_o(port_gnt), .wb_gnt_o(wb_gnt), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr), .cmd_we_o(cmd_we), .cmd_len_o(cmd_len),
    .cmd_src_o(cmd_src)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int idx, input int bank);
    return 32'h0010_0000 | (32'(bank) << 11) | (32'(idx) << 4);
  endfunction

  task automatic set_port(input int p, input int bank, input logic we, input int len);
    exp_addr[p] = mk_addr(p, bank); exp_we[p] = we; exp_len[p] = 4'(len);
    port_addr[p*32 +: 32] = exp_addr[p];
    port_we[p] = we;
    port_len[p*4 +: 4] = 4'(len);
    port_req[p] = 1'b1;
  endtask

  task automatic set_wb(input int p, input int bank, input int len);
    exp_addr[p+4] = mk_addr(p+4, bank); exp_we[p+4] = 1'b1; exp_len[p+4] = 4'(len);
    wb_addr[p*32 +: 32] = exp_addr[p+4];
    wb_len[p*4 +: 4] = 4'(len);
    wb_req[p] = 1'b1;
  endtask

  // called at a negedge; returns the accepted candidate index
  task automatic serve(output int src);
    int n = 0;
    while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
    src = int'(cmd_src);
    chk("R4 valid within wait", int'(cmd_valid), 1);
    chk("R9 address of selected", cmd_addr, exp_addr[src]);
    chk("R9 length of selected", cmd_len, exp_len[src]);
    chk("R2 direction of selected", cmd_we, exp_we[src]);
    chk("R9 grant bit", {wb_gnt, port_gnt}, 8'(1) << src);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    if (src < 4) port_req[src] = 1'b0; else wb_req[src-4] = 1'b0;
    chk("R4 idle after handshake", int'(cmd_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", int'(cmd_valid), 0);
    chk("R1 grants in reset", {wb_gnt, port_gnt}, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid after reset", int'(cmd_valid), 0);
    chk("R1 grants after reset", {wb_gnt, port_gnt}, 0);
  endtask

  task automatic t_single;
    int s;
    set_port(2, 1, 1'b0, 5);
    @(negedge clk);
    chk("R4 selected after one edge", int'(cmd_valid), 1);
    chk("R9 src single", cmd_src, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 valid held", int'(cmd_valid), 1);
      chk("R3 grant held", port_gnt, 4'b0100);
      chk("R3 address held", cmd_addr, exp_addr[2]);
    end
    serve(s);
    chk("R9 single src", s, 2);
  endtask

  task automatic t_conflict;
    int s;
    set_port(0, 1, 1'b0, 2);
    set_port(3, 2, 1'b1, 3);
    serve(s); chk("R5 free bank beats class", s, 3);
    serve(s); chk("R5 remaining", s, 0);
  endtask

  task automatic t_class;
    int s;
    set_port(2, 0, 1'b0, 1);
    set_port(1, 3, 1'b1, 4);
    serve(s); chk("R6 latency class first", s, 1);
    serve(s); chk("R6 throughput next", s, 2);
  endtask

  task automatic t_flush;
    int s;
    set_wb(1, 2, 8);
    serve(s);
    chk("R2 flush src", s, 5);
    chk("R2 flush was write", int'(exp_we[5]), 1);
  endtask

  task automatic t_rr;
    int s;
    set_port(1, 3, 1'b0, 1);
    set_wb(0, 3, 2);
    serve(s); chk("R7 first after pointer", s, 1);
    set_port(0, 3, 1'b0, 6);
    serve(s); chk("R7 rotation skips lower index", s, 4);
    serve(s); chk("R7 wrap to index 0", s, 0);
  endtask

  task automatic t_starve;
    int s;
    set_port(0, 0, 1'b0, 1);
    set_port(1, 1, 1'b0, 1);
    set_port(3, 2, 1'b0, 7);
    for (int i = 0; i < 8; i++) begin
      serve(s);
      chk("R8 not yet forced", int'(s == 3), 0);
      if (s == 0) set_port(0, 0, 1'b0, 1);
      if (s == 1) set_port(1, 1, 1'b0, 1);
    end
    serve(s);
    chk("R8 starved candidate forced", s, 3);
    port_req = '0;
    @(negedge clk);
    chk("R4 nothing pending", int'(cmd_valid), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_conflict();
    t_class();
    t_flush();
    t_rr();
    t_starve();
    finish_run();
  end
endmodule